// File: doc/BRIEF.md
# Multi-Channel Edge-Programmed PWM Generator

This block generates up to sixteen pulse-width-modulated outputs from one shared time base. An 8-bit prescaler divides the input clock into steps. An 8-bit step counter, common to every channel, counts those steps and defines the period. Each channel does not hold a duty value. It holds two absolute step positions: one where its output rises and one where it falls. Software programs the block through a byte-wide memory-mapped register port. Reads return their data one cycle after the request.

Any channel can be built with shadow copies of its edge positions. A global synchronous-update control decides how writes to those channels behave. When the control is off, writes take effect at once. When it is on, writes land only in the shadow copies, and the active edges take them over at the next counter wrap. A period that has already started therefore runs to its end unaltered.

Top module: `pwm_edge_gen`

## Requirements
- R1: The prescaler counts input clocks from 0 and produces one step after the clock in which its count reaches the prescale register, so each step lasts prescale+1 clocks. The prescale register sits at offset 0x00.
- R2: The step counter advances once per step and wraps to 0 after the step whose count has reached the period register (offset 0x04). One period is therefore (prescale+1)*(period+1) clocks. The wrap is the period boundary.
- R3: On the clock edge that ends step s of an enabled channel, the output is set to 1 when s equals the rising-edge value and cleared to 0 when s equals the falling-edge value. Between those edges the output holds. Channel i has its rising edge at offset 0x10+8*i and its falling edge at 0x14+8*i.
- R4: An edge value above the period value never matches, so that edge never occurs and the output can be held constant.
- R5: When a channel's rising and falling values are equal, the output inverts at that step, giving a 50% wave at twice the period.
- R6: Enable bit i is bit i of offset 0x08 for channels 0-7 and bit i-8 of offset 0x0C for channels 8-15. A disabled channel drives 0. An enable change acts at the next step boundary.
- R7: For a channel without shadows, or with the sync-update control off, an edge write changes the active value on the next clock, and readback shows the new value.
- R8: For a shadowed channel with sync update on (bit 0 of offset 0xE4), edge writes land only in the shadow. The active value, and its readback, changes only at the next period boundary.
- R9: A read returns its data on rdata in the cycle after rd_en. Unmapped offsets, edges of absent channels and enable bits of absent channels read as 0.
- R10: After reset, all registers, both counters, rdata and every output are 0, and sync update is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| pwm_o | output | NCH | Registered PWM outputs |

## Verification
Both counters and every output are registered. A change caused by the step that ends at clock edge k is visible just after edge k. Bus writes act on the clock edge that samples them, and read data follows one edge after rd_en. The bench drives inputs at the falling edge. It advances a cycle-accurate arithmetic reference model at each rising edge, using the values from before that edge, and compares all outputs at the next falling edge. Shadow checks first align to a known period boundary, so that the boundary on which a load is due is known exactly.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;
  localparam int REG_W = 8;
  localparam logic [7:0] OFS_PRESCALE = 8'h00;
  localparam logic [7:0] OFS_PERIOD   = 8'h04;
  localparam logic [7:0] OFS_EN_LO    = 8'h08;
  localparam logic [7:0] OFS_EN_HI    = 8'h0C;
  localparam logic [7:0] OFS_SYNC     = 8'hE4;
  localparam int         OFS_EDGE0    = 16;
  localparam int         EDGE_STRIDE  = 8;

  typedef struct packed {
    logic [REG_W-1:0] rise;
    logic [REG_W-1:0] fall;
  } edge_pair_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] prescale,
  input  logic [W-1:0] period,
  output logic         step_en,
  output logic         period_end,
  output logic [W-1:0] step
);
  logic [W-1:0] div_q;
  logic [W-1:0] step_q;

  // >= rather than == so that lowering a limit mid-count still wraps at once
  assign step_en    = (div_q >= prescale);
  assign period_end = step_en && (step_q >= period);
  assign step       = step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      step_q <= '0;
    end else begin
      div_q <= step_en ? '0 : div_q + 1'b1;
      if (step_en) step_q <= period_end ? '0 : step_q + 1'b1;
    end
  end

  // R1: a step restarts the prescaler
  p_div_restart_r1: assert property (@(posedge clk) disable iff (rst)
    step_en |=> (div_q == '0));

  // R2: the counter only advances by one or wraps to zero on a step
  p_step_advance_r2: assert property (@(posedge clk) disable iff (rst)
    step_en |=> ((step_q == '0) || (step_q == $past(step_q) + 1'b1)));

  // R2: the boundary always returns the counter to zero
  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (rst)
    period_end |=> (step_q == '0));
endmodule

// File: rtl/pwm_edge_chan.sv
module pwm_edge_chan
  import pwm_edge_pkg::*;
#(
  parameter int W        = 8,
  parameter bit SHADOWED = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_en,
  input  logic         period_end,
  input  logic         sync_on,
  input  logic         enable,
  input  logic [W-1:0] step,
  input  logic         wr_rise,
  input  logic         wr_fall,
  input  logic [W-1:0] wdata,
  output edge_pair_t   active,
  output logic         pwm_o
);
  edge_pair_t act_q;
  edge_pair_t sh_q;
  logic       load, direct, rise_hit, fall_hit, out_q;

  assign load     = SHADOWED && sync_on && period_end;
  assign direct   = !SHADOWED || !sync_on;
  assign rise_hit = (step == act_q.rise);
  assign fall_hit = (step == act_q.fall);

  generate
    if (SHADOWED) begin : g_shadow
      always_ff @(posedge clk) begin
        if (rst) begin
          sh_q <= '0;
        end else begin
          if (wr_rise) sh_q.rise <= wdata;
          if (wr_fall) sh_q.fall <= wdata;
        end
      end
    end else begin : g_direct
      assign sh_q = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      out_q <= 1'b0;
    end else begin
      if (load) act_q <= sh_q;
      if (wr_rise && direct) act_q.rise <= wdata;
      if (wr_fall && direct) act_q.fall <= wdata;
      if (step_en) begin
        if (!enable)                  out_q <= 1'b0;
        else if (rise_hit && fall_hit) out_q <= ~out_q;
        else if (rise_hit)             out_q <= 1'b1;
        else if (fall_hit)             out_q <= 1'b0;
      end
    end
  end

  assign active = act_q;
  assign pwm_o  = out_q;

  // R6: a disabled channel is low after the step boundary
  p_disabled_low_r6: assert property (@(posedge clk) disable iff (rst)
    (step_en && !enable) |=> !pwm_o);

  // R5: equal edges invert the output at the matching step
  p_equal_toggle_r5: assert property (@(posedge clk) disable iff (rst)
    (step_en && enable && (act_q.rise == act_q.fall) && (step == act_q.rise))
      |=> (pwm_o != $past(pwm_o)));

  // R8: with sync on, active edges of a shadowed channel move only at a boundary
  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (SHADOWED && sync_on && !period_end) |=> $stable(act_q));

  // R7: an unbuffered write is active on the next clock
  p_direct_write_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_rise && direct) |=> (act_q.rise == $past(wdata)));
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen
  import pwm_edge_pkg::*;
#(
  parameter int          NCH         = 16,
  parameter logic [15:0] SHADOW_MASK = 16'hFFFF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [7:0]     addr,
  input  logic [7:0]     wdata,
  output logic [7:0]     rdata,
  output logic [NCH-1:0] pwm_o
);
  localparam logic [15:0] CH_MASK = 16'((32'h1 << NCH) - 1);

  logic [REG_W-1:0] prescale_q, period_q;
  logic [15:0]      en_q;
  logic             sync_q;
  logic             step_en, period_end;
  logic [REG_W-1:0] step;
  logic [NCH-1:0]   wr_rise, wr_fall;
  edge_pair_t       act [NCH];
  logic [7:0]       rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      prescale_q <= '0;
      period_q   <= '0;
      en_q       <= '0;
      sync_q     <= 1'b0;
    end else if (wr_en) begin
      if (addr == OFS_PRESCALE) prescale_q <= wdata;
      if (addr == OFS_PERIOD)   period_q   <= wdata;
      if (addr == OFS_EN_LO)    en_q       <= {en_q[15:8], wdata} & CH_MASK;
      if (addr == OFS_EN_HI)    en_q       <= {wdata, en_q[7:0]} & CH_MASK;
      if (addr == OFS_SYNC)     sync_q     <= wdata[0];
    end
  end

  pwm_timebase #(.W(REG_W)) u_timebase (
    .clk        (clk),
    .rst        (rst),
    .prescale   (prescale_q),
    .period     (period_q),
    .step_en    (step_en),
    .period_end (period_end),
    .step       (step)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign wr_rise[i] = wr_en && (addr == 8'(OFS_EDGE0 + EDGE_STRIDE*i));
      assign wr_fall[i] = wr_en && (addr == 8'(OFS_EDGE0 + EDGE_STRIDE*i + 4));

      pwm_edge_chan #(.W(REG_W), .SHADOWED(SHADOW_MASK[i])) u_chan (
        .clk        (clk),
        .rst        (rst),
        .step_en    (step_en),
        .period_end (period_end),
        .sync_on    (sync_q),
        .enable     (en_q[i]),
        .step       (step),
        .wr_rise    (wr_rise[i]),
        .wr_fall    (wr_fall[i]),
        .wdata      (wdata),
        .active     (act[i]),
        .pwm_o      (pwm_o[i])
      );
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (addr == OFS_PRESCALE)   rd_mux = prescale_q;
    else if (addr == OFS_PERIOD) rd_mux = period_q;
    else if (addr == OFS_EN_LO)  rd_mux = en_q[7:0];
    else if (addr == OFS_EN_HI)  rd_mux = en_q[15:8];
    else if (addr == OFS_SYNC)   rd_mux = {7'b0, sync_q};
    else begin
      for (int i = 0; i < NCH; i++) begin
        if (addr == 8'(OFS_EDGE0 + EDGE_STRIDE*i))     rd_mux = act[i].rise;
        if (addr == 8'(OFS_EDGE0 + EDGE_STRIDE*i + 4)) rd_mux = act[i].fall;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R9: idle read port holds its data
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  // R6: enable bits of absent channels stay clear
  p_absent_en_r6: assert property (@(posedge clk) disable iff (rst)
    ((en_q & ~CH_MASK) == '0));
endmodule

// File: tb/pwm_edge_gen_tb_top.sv
module pwm_edge_gen_tb_top;
  localparam int          NCH = 4;
  localparam logic [15:0] SHM = 16'h000A;   // channels 1 and 3 shadowed
  localparam logic [15:0] MSK = 16'h000F;

  logic           clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]     addr = '0, wdata = '0, rdata;
  logic [NCH-1:0] pwm_o;

  pwm_edge_gen #(.NCH(NCH), .SHADOW_MASK(SHM)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o)
  );

  always #5 clk = ~clk;

  int vectors = 0, errors = 0;
  bit done = 1'b0;
  string req = "R10";

  // reference model state
  logic [7:0]     m_div = '0, m_step = '0, m_ps = '0, m_per = '0;
  logic [15:0]    m_en = '0;
  logic           m_sync = 1'b0;
  logic [7:0]     m_shr [NCH], m_shf [NCH], m_acr [NCH], m_acf [NCH];
  logic [NCH-1:0] m_out = '0;

  task automatic model_step();
    logic se, pe;
    if (rst) begin
      m_div = '0; m_step = '0; m_ps = '0; m_per = '0; m_en = '0; m_sync = 0; m_out = '0;
      for (int i = 0; i < NCH; i++) begin
        m_shr[i] = '0; m_shf[i] = '0; m_acr[i] = '0; m_acf[i] = '0;
      end
      return;
    end
    se = (m_div >= m_ps);
    pe = se && (m_step >= m_per);
    for (int i = 0; i < NCH; i++) begin
      if (se) begin
        if (!m_en[i]) m_out[i] = 1'b0;
        else if (m_step == m_acr[i] && m_step == m_acf[i]) m_out[i] = ~m_out[i];
        else if (m_step == m_acr[i]) m_out[i] = 1'b1;
        else if (m_step == m_acf[i]) m_out[i] = 1'b0;
      end
      if (SHM[i] && m_sync && pe) begin m_acr[i] = m_shr[i]; m_acf[i] = m_shf[i]; end
      if (wr_en && addr == 8'(16 + 8*i)) begin
        m_shr[i] = wdata;
        if (!SHM[i] || !m_sync) m_acr[i] = wdata;
      end
      if (wr_en && addr == 8'(20 + 8*i)) begin
        m_shf[i] = wdata;
        if (!SHM[i] || !m_sync) m_acf[i] = wdata;
      end
    end
    m_div = se ? 8'd0 : m_div + 8'd1;
    if (se) m_step = pe ? 8'd0 : m_step + 8'd1;
    if (wr_en) begin
      if (addr == 8'h00) m_ps = wdata;
      if (addr == 8'h04) m_per = wdata;
      if (addr == 8'h08) m_en = {m_en[15:8], wdata} & MSK;
      if (addr == 8'h0C) m_en = {wdata, m_en[7:0]} & MSK;
      if (addr == 8'hE4) m_sync = wdata[0];
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    vectors++;
    if (pwm_o !== m_out) begin
      errors++;
      $display("FAIL %s pwm_o actual=%b expected=%b step=%0d", req, pwm_o, m_out, m_step);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    cycle();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string r);
    rd_en = 1'b1; addr = a;
    cycle();
    rd_en = 1'b0;
    vectors++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s read 0x%02h actual=0x%02h expected=0x%02h", r, a, rdata, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired during %s", req);
      finish_run();
    end
  end

  initial begin
    req = "R10";
    repeat (3) cycle();
    rst = 1'b0;
    // R10: reset state
    rd(8'h00, 8'h00, "R10"); rd(8'h04, 8'h00, "R10"); rd(8'h08, 8'h00, "R10");
    rd(8'h10, 8'h00, "R10"); rd(8'hE4, 8'h00, "R10");
    // R1, R2, R9: time base registers and readback
    wr(8'h00, 8'd1); wr(8'h04, 8'd5);
    rd(8'h00, 8'd1, "R1"); rd(8'h04, 8'd5, "R2");
    rd(8'h44, 8'h00, "R9");            // beyond the last present channel
    wr(8'h0C, 8'hFF); rd(8'h0C, 8'h00, "R9");
    wr(8'h08, 8'hFF); rd(8'h08, 8'h0F, "R6");
    wr(8'h08, 8'h01);
    // R3/R4/R5: sweep both edges of channel 0 over and beyond the period
    for (int r = 0; r < 7; r++) begin
      for (int f = 0; f < 7; f++) begin
        req = (r > 5 || f > 5) ? "R4" : (r == f) ? "R5" : "R3";
        wr(8'h10, 8'(r)); wr(8'h14, 8'(f));
        repeat (24) cycle();
      end
    end
    // R7: unbuffered channel reads back its new edge at once
    wr(8'h10, 8'd1); rd(8'h10, 8'd1, "R7");
    wr(8'h14, 8'd4);
    // R2/R1: prescale sweep with a fixed waveform
    for (int p = 0; p < 3; p++) begin
      req = "R1";
      wr(8'h00, 8'(p));
      repeat (40) cycle();
    end
    wr(8'h00, 8'd1);
    req = "R2"; repeat (30) cycle();
    // R7: shadowed channel with sync off writes straight through
    wr(8'h28, 8'd4); rd(8'h28, 8'd4, "R7");
    wr(8'h2C, 8'd1);
    wr(8'h08, 8'h0B);
    req = "R7"; repeat (30) cycle();
    // R8: sync on, shadowed channel 1 waits for the boundary
    wr(8'hE4, 8'h01); rd(8'hE4, 8'h01, "R8");
    req = "R8";
    while (!(m_step == 8'd0 && m_div == 8'd0)) cycle();
    wr(8'h18, 8'd2); wr(8'h1C, 8'd4);
    rd(8'h18, 8'h00, "R8");
    repeat (3) cycle();
    rd(8'h1C, 8'h00, "R8");
    repeat (12) cycle();
    rd(8'h18, 8'd2, "R8"); rd(8'h1C, 8'd4, "R8");
    // R7: unshadowed channel 0 still immediate with sync on
    wr(8'h10, 8'd3); rd(8'h10, 8'd3, "R7");
    repeat (30) cycle();
    // R6: disable channel 0 mid-step, output falls at next boundary
    req = "R6";
    wr(8'h08, 8'h0A);
    repeat (30) cycle();
    vectors++;
    if (pwm_o[0] !== 1'b0) begin
      errors++;
      $display("FAIL R6 disabled output actual=%b expected=0", pwm_o[0]);
    end
    req = "R10";
    rst = 1'b1; repeat (2) cycle(); rst = 1'b0;
    rd(8'h18, 8'h00, "R10"); rd(8'hE4, 8'h00, "R10");
    done = 1'b1;
    finish_run();
  end
endmodule